// File: doc/BRIEF.md
# Indexed Mode Flag Bank

This block holds two small banks of single-bit mode flags that a host updates one byte at a time. On the primary bank a byte whose upper nibble is zero names one of eight flags and carries the value to load into it, so software can touch a single flag without a read-modify-write. A change to certain primary flags produces a one-cycle redraw request for the graphics plane, the text plane or the palette, which display logic downstream uses to schedule a repaint.

A second mode port drives a four-bit auxiliary bank with the same kind of encoding. It also recognises a few whole-byte command codes: two pairs that clear or set a display-type flag, and one pair that clears or sets an extended-colour flag only while auxiliary flag 3 is set. A third port loads a selector byte. The selector picks one flag, or a constant, to appear on a byte-wide read-back output, and the whole primary byte is also available directly.

All three write ports are plain single-cycle strobes that are accepted in every cycle. There is no back-pressure, so no ready signal exists. Every output is a registered value, or a combinational selection of registered values, and is valid in the cycle after the strobe.

Top module: `mode_flag_bank`

## Requirements
- R1: After reset the primary byte reads 0x98, the auxiliary bank, the display-type flag and the extended-colour flag read 0, no redraw request is active, and the selector is 0x00, so the read-back output is 0xFF.
- R2: A primary write with bits [7:4] equal to 0 loads bit 0 of the byte into primary flag number bits [3:1]. The new byte is visible on `mode1_o` in the next cycle, and the other seven flags keep their values.
- R3: A primary write with any of bits [7:4] set leaves all eight primary flags unchanged and raises no redraw request.
- R4: When a primary write changes the value of flag 0, 2 or 4, `redraw_gfx_o` is high for exactly the next cycle. A write that loads a flag with the value it already holds raises no request.
- R5: When a primary write changes flag 1, both `redraw_gfx_o` and `redraw_pal_o` are high for exactly the next cycle.
- R6: When a primary write changes flag 3, `redraw_txt_o` alone is high for exactly the next cycle. Flags 5, 6 and 7 raise no request.
- R7: An auxiliary write with bits [7:3] equal to 0 loads bit 0 into auxiliary flag number bits [2:1].
- R8: Auxiliary codes 0x40 and 0x80 clear the display-type flag, and codes 0x41 and 0x81 set it. No other code changes it.
- R9: Auxiliary codes 0x20 and 0x21 clear and set the extended-colour flag only while auxiliary flag 3 is 1. While that flag is 0, both codes have no effect.
- R10: The read-back output follows the selector: 0x00 gives 0xFF, 0x01, 0x02 and 0x03 give primary bits 1, 4 and 7, 0x04, 0x07 and 0x08 give auxiliary bits 0, 2 and 3, and 0x0B gives 1. A single flag appears in bit 0 with the upper bits zero.
- R11: Every selector value not listed in R10 gives a read-back value of 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m1_wr | input | 1 | Primary bank write strobe |
| m1_wdata | input | 8 | Primary bank write byte |
| m2_wr | input | 1 | Auxiliary port write strobe |
| m2_wdata | input | 8 | Auxiliary port write byte or command code |
| idx_wr | input | 1 | Selector write strobe |
| idx_wdata | input | 8 | New selector value |
| mode1_o | output | 8 | Primary flag byte |
| mode2_o | output | 4 | Auxiliary flags |
| disp_type_o | output | 1 | Display-type flag |
| ext_color_o | output | 1 | Extended-colour flag |
| redraw_gfx_o | output | 1 | Graphics redraw request pulse |
| redraw_pal_o | output | 1 | Palette change request pulse |
| redraw_txt_o | output | 1 | Text redraw request pulse |
| sel_data_o | output | 8 | Indexed read-back value |

## Verification
The assertions take for granted that the strobes and their data bytes are never unknown at a rising edge once reset is released, and that each byte is held stable while its strobe is high. The bench drives every input on the falling edge and holds it for a whole cycle, then drops the strobe. Its random data is biased toward zero upper nibbles and toward the listed command codes, so that flag writes, redundant writes, gated extended-colour commands while auxiliary flag 3 is both clear and set, and unlisted selector values all occur many times.

// File: rtl/mflag_pkg.sv
package mflag_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_DISP_CLR     = 8'h40;
  localparam logic [BYTE_W-1:0] CODE_DISP_SET     = 8'h41;
  localparam logic [BYTE_W-1:0] CODE_DISP_CLR_ALT = 8'h80;
  localparam logic [BYTE_W-1:0] CODE_DISP_SET_ALT = 8'h81;
  localparam logic [BYTE_W-1:0] CODE_EXT_CLR      = 8'h20;
  localparam logic [BYTE_W-1:0] CODE_EXT_SET      = 8'h21;

  typedef enum logic [BYTE_W-1:0] {
    SEL_ALL   = 8'h00,
    SEL_P1    = 8'h01,
    SEL_P4    = 8'h02,
    SEL_P7    = 8'h03,
    SEL_A0    = 8'h04,
    SEL_A2    = 8'h07,
    SEL_A3    = 8'h08,
    SEL_CONST = 8'h0b
  } sel_code_e;

  typedef struct packed {
    logic gfx;
    logic pal;
    logic txt;
  } redraw_t;
endpackage

// File: rtl/mflag_primary_bank.sv
module mflag_primary_bank
  import mflag_pkg::*;
#(
  parameter int               FLAG_N   = 8,
  parameter logic [FLAG_N-1:0] RST_VAL  = 8'h98,
  parameter logic [FLAG_N-1:0] GFX_MASK = 8'h17,
  parameter logic [FLAG_N-1:0] PAL_MASK = 8'h02,
  parameter logic [FLAG_N-1:0] TXT_MASK = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [FLAG_N-1:0] flags_o,
  output redraw_t           redraw_o
);
  localparam int IDX_W = $clog2(FLAG_N);

  logic              accept;
  logic [IDX_W-1:0]  sel_bit;
  logic [FLAG_N-1:0] flag_q;
  logic [FLAG_N-1:0] flip;
  redraw_t           redraw_q;

  assign accept  = wr_en && (wr_data[BYTE_W-1:IDX_W+1] == '0);
  assign sel_bit = wr_data[IDX_W:1];

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic hit;
    assign hit     = accept && (sel_bit == IDX_W'(i));
    assign flip[i] = hit && (flag_q[i] != wr_data[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= RST_VAL[i];
      end else if (hit) begin
        flag_q[i] <= wr_data[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redraw_q <= '0;
    end else begin
      redraw_q.gfx <= |(flip & GFX_MASK);
      redraw_q.pal <= |(flip & PAL_MASK);
      redraw_q.txt <= |(flip & TXT_MASK);
    end
  end

  assign flags_o  = flag_q;
  assign redraw_o = redraw_q;
endmodule

// File: rtl/mflag_aux_decoder.sv
module mflag_aux_decoder
  import mflag_pkg::*;
#(
  parameter int AUX_N    = 4,
  parameter int EXT_GATE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [AUX_N-1:0]  aux_o,
  output logic              disp_o,
  output logic              ext_o
);
  localparam int AIDX_W = $clog2(AUX_N);

  logic             flag_wr;
  logic [AUX_N-1:0] aux_q;
  logic             disp_q;
  logic             ext_q;
  logic             ext_ok;

  assign flag_wr = wr_en && (wr_data[BYTE_W-1:AIDX_W+1] == '0);
  assign ext_ok  = aux_q[EXT_GATE];

  for (genvar i = 0; i < AUX_N; i++) begin : g_aux
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        aux_q[i] <= 1'b0;
      end else if (flag_wr && (wr_data[AIDX_W:1] == AIDX_W'(i))) begin
        aux_q[i] <= wr_data[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (wr_en && !flag_wr) begin
      unique case (wr_data)
        CODE_DISP_CLR, CODE_DISP_CLR_ALT: disp_q <= 1'b0;
        CODE_DISP_SET, CODE_DISP_SET_ALT: disp_q <= 1'b1;
        CODE_EXT_CLR: if (ext_ok) ext_q <= 1'b0;
        CODE_EXT_SET: if (ext_ok) ext_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign aux_o  = aux_q;
  assign disp_o = disp_q;
  assign ext_o  = ext_q;
endmodule

// File: rtl/mflag_readback.sv
module mflag_readback
  import mflag_pkg::*;
#(
  parameter int FLAG_N = 8,
  parameter int AUX_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] idx_wdata,
  input  logic [FLAG_N-1:0] prim,
  input  logic [AUX_N-1:0]  aux,
  output logic [BYTE_W-1:0] sel_data
);
  logic [BYTE_W-1:0] sel_q;
  logic              bit_val;
  logic              use_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_ALL;
    end else if (idx_wr) begin
      sel_q <= idx_wdata;
    end
  end

  always_comb begin
    bit_val = 1'b0;
    use_all = 1'b0;
    case (sel_q)
      SEL_ALL:   use_all = 1'b1;
      SEL_P1:    bit_val = prim[1];
      SEL_P4:    bit_val = prim[4];
      SEL_P7:    bit_val = prim[7];
      SEL_A0:    bit_val = aux[0];
      SEL_A2:    bit_val = aux[2];
      SEL_A3:    bit_val = aux[3];
      SEL_CONST: bit_val = 1'b1;
      default:   bit_val = 1'b0;
    endcase
  end

  assign sel_data = use_all ? '1 : {{(BYTE_W-1){1'b0}}, bit_val};
endmodule

// File: rtl/mode_flag_bank.sv
module mode_flag_bank
  import mflag_pkg::*;
#(
  parameter int FLAG_N = 8,
  parameter int AUX_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m1_wr,
  input  logic [7:0]        m1_wdata,
  input  logic              m2_wr,
  input  logic [7:0]        m2_wdata,
  input  logic              idx_wr,
  input  logic [7:0]        idx_wdata,
  output logic [FLAG_N-1:0] mode1_o,
  output logic [AUX_N-1:0]  mode2_o,
  output logic              disp_type_o,
  output logic              ext_color_o,
  output logic              redraw_gfx_o,
  output logic              redraw_pal_o,
  output logic              redraw_txt_o,
  output logic [7:0]        sel_data_o
);
  redraw_t redraw;

  mflag_primary_bank #(.FLAG_N(FLAG_N)) u_prim (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (m1_wr),
    .wr_data  (m1_wdata),
    .flags_o  (mode1_o),
    .redraw_o (redraw)
  );

  mflag_aux_decoder #(.AUX_N(AUX_N)) u_aux (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (m2_wr),
    .wr_data (m2_wdata),
    .aux_o   (mode2_o),
    .disp_o  (disp_type_o),
    .ext_o   (ext_color_o)
  );

  mflag_readback #(.FLAG_N(FLAG_N), .AUX_N(AUX_N)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .idx_wdata (idx_wdata),
    .prim      (mode1_o),
    .aux       (mode2_o),
    .sel_data  (sel_data_o)
  );

  assign redraw_gfx_o = redraw.gfx;
  assign redraw_pal_o = redraw.pal;
  assign redraw_txt_o = redraw.txt;
endmodule

// File: rtl/mode_flag_bank_chk.sv
module mode_flag_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       m1_wr,
  input logic [7:0] m1_wdata,
  input logic       m2_wr,
  input logic [7:0] m2_wdata,
  input logic       idx_wr,
  input logic [7:0] idx_wdata,
  input logic [7:0] mode1_o,
  input logic [3:0] mode2_o,
  input logic       disp_type_o,
  input logic       ext_color_o,
  input logic       redraw_gfx_o,
  input logic       redraw_pal_o,
  input logic       redraw_txt_o,
  input logic [7:0] sel_data_o
);
  assert_set_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_wr && m1_wdata[7:4] == 4'h0) |=>
      (mode1_o[$past(m1_wdata[3:1])] == $past(m1_wdata[0])));

  assert_ignore_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_wr && m1_wdata[7:4] != 4'h0) |=> $stable(mode1_o));

  assert_pulse_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redraw_gfx_o |-> (mode1_o != $past(mode1_o)));

  assert_pal_with_gfx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redraw_pal_o |-> redraw_gfx_o);

  assert_txt_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redraw_txt_o |-> !redraw_gfx_o);

  assert_disp_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m2_wr && (m2_wdata == 8'h41 || m2_wdata == 8'h81)) |=> disp_type_o);

  assert_ext_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m2_wr && m2_wdata[7:1] == 7'h10 && !mode2_o[3]) |=> $stable(ext_color_o));

  assert_sel_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && idx_wdata == 8'h00) |=> (sel_data_o == 8'hff));
endmodule

bind mode_flag_bank mode_flag_bank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .m1_wr        (m1_wr),
  .m1_wdata     (m1_wdata),
  .m2_wr        (m2_wr),
  .m2_wdata     (m2_wdata),
  .idx_wr       (idx_wr),
  .idx_wdata    (idx_wdata),
  .mode1_o      (mode1_o),
  .mode2_o      (mode2_o),
  .disp_type_o  (disp_type_o),
  .ext_color_o  (ext_color_o),
  .redraw_gfx_o (redraw_gfx_o),
  .redraw_pal_o (redraw_pal_o),
  .redraw_txt_o (redraw_txt_o),
  .sel_data_o   (sel_data_o)
);

// File: tb/mode_flag_bank_tb.sv
module mode_flag_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m1_wr = 1'b0;
  logic [7:0] m1_wdata = '0;
  logic       m2_wr = 1'b0;
  logic [7:0] m2_wdata = '0;
  logic       idx_wr = 1'b0;
  logic [7:0] idx_wdata = '0;
  logic [7:0] mode1_o;
  logic [3:0] mode2_o;
  logic       disp_type_o, ext_color_o;
  logic       redraw_gfx_o, redraw_pal_o, redraw_txt_o;
  logic [7:0] sel_data_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] e_m1;
  logic [3:0] e_m2;
  logic       e_dt, e_ec, e_g, e_p, e_t;
  logic [7:0] e_idx;

  always #2 clk = ~clk;

  mode_flag_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .m1_wr(m1_wr), .m1_wdata(m1_wdata),
    .m2_wr(m2_wr), .m2_wdata(m2_wdata),
    .idx_wr(idx_wr), .idx_wdata(idx_wdata),
    .mode1_o(mode1_o), .mode2_o(mode2_o),
    .disp_type_o(disp_type_o), .ext_color_o(ext_color_o),
    .redraw_gfx_o(redraw_gfx_o), .redraw_pal_o(redraw_pal_o),
    .redraw_txt_o(redraw_txt_o), .sel_data_o(sel_data_o)
  );

  function automatic logic [7:0] exp_sel();
    case (e_idx)
      8'h00: return 8'hff;
      8'h01: return {7'b0, e_m1[1]};
      8'h02: return {7'b0, e_m1[4]};
      8'h03: return {7'b0, e_m1[7]};
      8'h04: return {7'b0, e_m2[0]};
      8'h07: return {7'b0, e_m2[2]};
      8'h08: return {7'b0, e_m2[3]};
      8'h0b: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string hint);
    check(hint == "" ? "R2" : hint, "mode1_o", int'(mode1_o), int'(e_m1));
    check("R7", "mode2_o", int'(mode2_o), int'(e_m2));
    check("R8", "disp_type_o", int'(disp_type_o), int'(e_dt));
    check("R9", "ext_color_o", int'(ext_color_o), int'(e_ec));
    check("R4", "redraw_gfx_o", int'(redraw_gfx_o), int'(e_g));
    check("R5", "redraw_pal_o", int'(redraw_pal_o), int'(e_p));
    check("R6", "redraw_txt_o", int'(redraw_txt_o), int'(e_t));
    check((e_idx > 8'h0b || e_idx == 8'h05 || e_idx == 8'h06 || e_idx == 8'h09 || e_idx == 8'h0a)
          ? "R11" : "R10", "sel_data_o", int'(sel_data_o), int'(exp_sel()));
  endtask

  // Called on a falling edge; applies one cycle of stimulus and checks the result.
  task automatic step(bit w1, logic [7:0] d1, bit w2, logic [7:0] d2,
                      bit wi, logic [7:0] di, string hint = "");
    int b;
    m1_wr = w1; m1_wdata = d1;
    m2_wr = w2; m2_wdata = d2;
    idx_wr = wi; idx_wdata = di;
    @(posedge clk);
    e_g = 0; e_p = 0; e_t = 0;
    if (w1 && d1[7:4] == 4'h0) begin
      b = int'(d1[3:1]);
      if (e_m1[b] != d1[0]) begin
        e_m1[b] = d1[0];
        if (b == 0 || b == 2 || b == 4) e_g = 1;
        if (b == 1) begin e_g = 1; e_p = 1; end
        if (b == 3) e_t = 1;
      end
    end
    if (w2) begin
      if (d2[7:3] == 5'h0) e_m2[int'(d2[2:1])] = d2[0];
      else if (d2 == 8'h40 || d2 == 8'h80) e_dt = 0;
      else if (d2 == 8'h41 || d2 == 8'h81) e_dt = 1;
      else if (d2 == 8'h20 && e_m2[3]) e_ec = 0;
      else if (d2 == 8'h21 && e_m2[3]) e_ec = 1;
    end
    if (wi) e_idx = di;
    @(negedge clk);
    m1_wr = 0; m2_wr = 0; idx_wr = 0;
    compare_all(hint);
  endtask

  function automatic logic [7:0] pick_code();
    int r = int'($urandom % 10);
    case (r)
      0: return 8'h40; 1: return 8'h41; 2: return 8'h80; 3: return 8'h81;
      4: return 8'h20; 5: return 8'h21;
      6, 7: return {5'h0, 3'($urandom)};
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    e_m1 = 8'h98; e_m2 = 4'h0; e_dt = 0; e_ec = 0;
    e_g = 0; e_p = 0; e_t = 0; e_idx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");   // R1 reset state, selector 0 gives 0xFF

    // R2 / R4: clear flag 4 (changes), then set it back
    step(1, 8'h08, 0, 0, 0, 0);
    check("R4", "gfx pulse on flag 4 clear", int'(redraw_gfx_o), 1);
    step(1, 8'h09, 0, 0, 0, 0);
    // R4: redundant write, no pulse
    step(1, 8'h09, 0, 0, 0, 0);
    check("R4", "no pulse on redundant write", int'(redraw_gfx_o), 0);
    // R5: flag 1 change
    step(1, 8'h03, 0, 0, 0, 0);
    check("R5", "pal pulse on flag 1", int'(redraw_pal_o), 1);
    // R6: flag 3 change, flag 6 change
    step(1, 8'h06, 0, 0, 0, 0);
    check("R6", "txt pulse on flag 3", int'(redraw_txt_o), 1);
    step(1, 8'h0d, 0, 0, 0, 0);
    check("R6", "no request for flag 6", int'(redraw_gfx_o | redraw_txt_o), 0);
    // R3: upper nibble set, ignored
    step(1, 8'h10, 0, 0, 0, 0, "R3");
    step(1, 8'hf7, 0, 0, 0, 0, "R3");
    check("R3", "mode1 after ignored writes", int'(mode1_o), int'(e_m1));
    // R9: gated off while aux flag 3 is 0
    step(0, 0, 1, 8'h21, 0, 0);
    check("R9", "ext stays 0 when gated", int'(ext_color_o), 0);
    step(0, 0, 1, 8'h07, 0, 0);   // R7 set aux flag 3
    step(0, 0, 1, 8'h21, 0, 0);
    check("R9", "ext set when enabled", int'(ext_color_o), 1);
    // R8: aliases
    step(0, 0, 1, 8'h81, 0, 0);
    check("R8", "disp set via 0x81", int'(disp_type_o), 1);
    step(0, 0, 1, 8'h40, 0, 0);
    check("R8", "disp clear via 0x40", int'(disp_type_o), 0);
    // R10 / R11 read-back
    step(0, 0, 0, 0, 1, 8'h08);
    check("R10", "sel 0x08 gives aux bit 3", int'(sel_data_o), 1);
    step(0, 0, 0, 0, 1, 8'h0b);
    check("R10", "sel 0x0b gives 1", int'(sel_data_o), 1);
    step(0, 0, 0, 0, 1, 8'h05);
    check("R11", "sel 0x05 gives 0", int'(sel_data_o), 0);
    step(0, 0, 0, 0, 1, 8'h0a);
    check("R11", "sel 0x0a gives 0", int'(sel_data_o), 0);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] d1;
      logic [7:0] di;
      d1 = ($urandom % 4 == 0) ? 8'($urandom) : {4'h0, 4'($urandom)};
      di = ($urandom % 8 == 0) ? 8'($urandom) : {4'h0, 4'($urandom)};
      step(1'($urandom), d1, 1'($urandom), pick_code(), 1'($urandom % 3 == 0), di);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule